// File: doc/BRIEF.md
# Opcode-Driven Instruction Timing Sequencer

This block is the timing core of a small control unit. It walks through eight timing states, T0 to T7, and raises exactly one timing pulse per state so that downstream control logic knows which step of the current instruction is active. The first four states form the instruction fetch phase. They always run in order, whatever the opcode. The states from T4 onwards form the execute phase, and its length is chosen by the low two bits of a 3-bit opcode.

The state lives in a three-bit binary register. The next-state logic is a set of Boolean equations on the state bits and the opcode bits. When the current execute state equals T(4 + opcode[1:0]), the sequencer returns to T0. In every other state it advances by one, and T7 wraps to T0. A single flag, `exec_phase`, separates fetch from execute. The opcode is assumed to stay stable from T3 until the instruction completes.

The named states are T0, T1, T2, T3 (fetch) and T4, T5, T6, T7 (execute). The transitions are: reset to T0; T0 to T1, T1 to T2, T2 to T3 and T3 to T4 without condition. From Tk with k at least 4, the sequencer goes to T0 when k equals 4 + opcode[1:0]. Otherwise it goes to T(k+1), and T7 always goes to T0.

Top module: `opcode_timing_seq`

## Requirements
- R1: With `rst` high at a rising edge of `clk`, the sequencer is in T0 after that edge: `tpulse` equals 8'b0000_0001 and `exec_phase` equals 0.
- R2: `tpulse` is one-hot at all times after reset, and bit k of `tpulse` is high exactly while the state is Tk.
- R3: `exec_phase` is 0 in T0 to T3 and 1 in T4 to T7.
- R4: T0, T1, T2 and T3 each advance to the next state at the next edge, for any opcode.
- R5: In execute state Tk, the next state is T0 when k equals 4 + opcode[1:0]. Otherwise it is T(k+1), with T7 going to T0. One instruction therefore lasts 5 + opcode[1:0] cycles from T0 to T0.
- R6: opcode bit 2 has no effect: opcodes 4 to 7 give the same sequence as opcodes 0 to 3.
- R7: Asserting `rst` in the middle of an instruction, in either phase, returns the sequencer to T0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to T0 |
| op | input | 3 | Opcode; bits 1:0 select the last execute state |
| tpulse | output | 8 | Timing pulses; bit k is high in state Tk |
| exec_phase | output | 1 | 0 during fetch (T0–T3), 1 during execute (T4–T7) |

## Verification
The assertions check, on every clock, that the pulses are one-hot and that the execute flag agrees with them. They also check each single-step transition: fetch states advance, the selected last execute state returns to T0, other execute states advance, and T0 follows a released reset. Only the bench's scenarios show the whole-instruction lengths for each opcode, the equality between opcodes with and without bit 2 set, and recovery from a reset asserted in the middle of fetch and in the middle of execute.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int ST_W      = 3;
    localparam int OP_W      = 3;
    localparam int NUM_T     = 1 << ST_W;
    localparam int FETCH_LEN = NUM_T / 2;

    typedef enum logic [ST_W-1:0] {
        T0 = 3'd0, T1 = 3'd1, T2 = 3'd2, T3 = 3'd3,
        T4 = 3'd4, T5 = 3'd5, T6 = 3'd6, T7 = 3'd7
    } tstate_e;
endpackage

// File: rtl/seq_next.sv
// Next-state equations in plain Boolean form: ripple increment, cleared
// when the current execute state matches the selected last state.
module seq_next #(
    parameter int ST_W = 3
) (
    input  logic [ST_W-1:0] cur,
    input  logic [ST_W-2:0] sel,
    output logic [ST_W-1:0] nxt
);
    logic [ST_W:0]   carry;
    logic [ST_W-1:0] inc;
    logic [ST_W-2:0] match;
    logic            last_st;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < ST_W; i++) begin : g_inc
        assign inc[i]     = cur[i] ^ carry[i];
        assign carry[i+1] = cur[i] & carry[i];
    end

    for (genvar j = 0; j < ST_W - 1; j++) begin : g_match
        assign match[j] = ~(cur[j] ^ sel[j]);
    end

    // last execute state: upper bit set and low bits equal to selector
    assign last_st = cur[ST_W-1] & (&match);
    assign nxt     = inc & {ST_W{~last_st}};
endmodule

// File: rtl/seq_decode.sv
// Output decode: one pulse per state, execute flag from the top state bit.
module seq_decode #(
    parameter int ST_W  = 3,
    localparam int NUM_T = 1 << ST_W
) (
    input  logic [ST_W-1:0]  cur,
    output logic [NUM_T-1:0] pulse,
    output logic             exec_o
);
    for (genvar i = 0; i < NUM_T; i++) begin : g_pulse
        assign pulse[i] = (cur == ST_W'(i));
    end

    assign exec_o = cur[ST_W-1];
endmodule

// File: rtl/opcode_timing_seq.sv
module opcode_timing_seq
    import seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  op,
    output logic [NUM_T-1:0] tpulse,
    output logic             exec_phase
);
    tstate_e         state_q;
    logic [ST_W-1:0] nxt_bits;

    seq_next #(.ST_W(ST_W)) u_next (
        .cur (state_q),
        .sel (op[ST_W-2:0]),
        .nxt (nxt_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= T0;
        end else begin
            state_q <= tstate_e'(nxt_bits);
        end
    end

    seq_decode #(.ST_W(ST_W)) u_decode (
        .cur    (state_q),
        .pulse  (tpulse),
        .exec_o (exec_phase)
    );
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] op,
    input logic [7:0] tpulse,
    input logic       exec_phase
);
    logic rst_q = 1'b0;
    always_ff @(posedge clk) rst_q <= rst;

    p_reset_t0_r1: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (tpulse == 8'h01 && !exec_phase));

    p_onehot_r2: assert property (@(posedge clk) disable iff (rst || rst_q === 1'bx)
        rst_q == 1'b0 |-> $countones(tpulse) == 1);

    p_exec_flag_r3: assert property (@(posedge clk) disable iff (rst)
        !rst_q |-> exec_phase == (|tpulse[7:4]));

    p_fetch_adv_r4: assert property (@(posedge clk) disable iff (rst)
        (|tpulse[3:0]) |=> tpulse == ($past(tpulse) << 1));

    p_exec_end_r5: assert property (@(posedge clk) disable iff (rst)
        (exec_phase && tpulse[{1'b1, op[1:0]}]) |=> tpulse == 8'h01);

    p_exec_adv_r5: assert property (@(posedge clk) disable iff (rst)
        (exec_phase && !tpulse[{1'b1, op[1:0]}] && !tpulse[7])
            |=> tpulse == ($past(tpulse) << 1));
endmodule

bind opcode_timing_seq seq_checker u_seq_checker (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .tpulse     (tpulse),
    .exec_phase (exec_phase)
);

// File: tb/tb_opcode_timing_seq.sv
module tb_opcode_timing_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] op  = 3'd0;
    logic [7:0] tpulse;
    logic       exec_phase;

    int tests = 0;
    int fails = 0;
    int m_st  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    opcode_timing_seq dut (
        .clk(clk), .rst(rst), .op(op), .tpulse(tpulse), .exec_phase(exec_phase)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst)                         m_st <= 0;
        else if (m_st < 4)               m_st <= m_st + 1;
        else if (m_st == 4 + (op % 4))   m_st <= 0;
        else                             m_st <= (m_st + 1) % 8;
    end

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R2, R3)
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("R2 pulse", int'(tpulse), 1 << m_st);
            check("R3 exec", int'(exec_phase), (m_st >= 4) ? 1 : 0);
        end
    end

    task automatic run_instr(input logic [2:0] o, input string tag);
        int cnt = 0;
        op = o;
        do begin
            @(negedge clk);
            cnt++;
            if (cnt <= 3) check("R4 fetch step", int'(tpulse), 1 << cnt);
        end while (tpulse[0] !== 1'b1 && cnt < 20);
        check(tag, cnt, 5 + int'(o[1:0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset pulse", int'(tpulse), 1);
        check("R1 reset exec", int'(exec_phase), 0);
        cmp_on = 1'b1;
        rst = 1'b0;
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 3; k++) begin
                run_instr(3'(o), (o >= 4) ? "R6 length" : "R5 length");
            end
        end
        // back-to-back alternating lengths
        run_instr(3'd3, "R5 length");
        run_instr(3'd0, "R5 length");
        run_instr(3'd6, "R6 length");
        // reset in execute phase (T6)
        op = 3'd3;
        repeat (6) @(negedge clk);
        check("R7 mid exec state", int'(tpulse), 8'h40);
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset from exec", int'(tpulse), 1);
        rst = 1'b0;
        // reset in fetch phase (T2)
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R7 reset from fetch", int'(tpulse), 1);
        check("R7 exec after reset", int'(exec_phase), 0);
        rst = 1'b0;
        run_instr(3'd1, "R5 after reset");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule